// File: doc/BRIEF.md
# Six-Step Commutation Sequencer

This block steps a three-phase bridge through the six switching states of one electrical cycle of a sensorless brushless DC motor. Each one-cycle pulse on the step enable moves the sequence one state forward. The pulse comes from an external oscillator or a numerically controlled oscillator that tracks rotor speed. A direction input picks the order of the states. In every state the block gives the raw on-requests for the three low-side and three high-side switches. It also gives a two-bit code that names the phase left floating, so that a back-EMF sampler knows which winding to measure.

A synchronous reset puts the block into an alignment state. In that state three switches are on together, which pulls the rotor to a known position before the open-loop start. The first step after alignment always enters run state A. PWM gating, current limiting and the analog measurement live in other blocks.

Top module: `comm_seq_top`

## Requirements
- R1: While reset is high, and on the first sampling point after reset, the block is in the alignment state. Its outputs are lowReq=3'b010, highReq=3'b101 and senseSel=2'd3. Bit 0, 1 and 2 of each request vector stand for phase A, B and C. senseSel codes 0, 1 and 2 name phase A, B and C, and code 3 means no phase is sampled.
- R2: A step pulse in the alignment state moves the block to state A (lowReq=3'b100, highReq=3'b001, senseSel=1), whatever the direction.
- R3: With direction high at alignment time, each step follows A→B→C→D→E→F→A. The states are B (100,010,0), C (001,010,2), D (001,100,1), E (010,100,0) and F (010,001,2), each given as (lowReq, highReq, senseSel).
- R4: With direction low at alignment time, each step follows A→F→E→D→C→B→A, using the same per-state output values.
- R5: In a cycle with no step pulse, all outputs hold their values.
- R6: The direction input is captured only while the block is in the alignment state. A change during run has no effect until the next reset.
- R7: In every run state exactly one low-side request and exactly one high-side request are set, and they belong to different phases.
- R8: In every run state senseSel names the phase that has neither its low-side nor its high-side request set.
- R9: Outputs are registered. All of them change together on the clock edge that samples a step pulse. A step enable held high for N cycles advances N states.
- R10: Reset takes priority over a step pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset into the alignment state |
| stepEn | input | 1 | Commutation step enable, one cycle per step |
| dirFwd | input | 1 | Direction select, 1 = forward order, sampled only in alignment |
| lowReq | output | 3 | Low-side switch requests, bit0=A, bit1=B, bit2=C |
| highReq | output | 3 | High-side switch requests, bit0=A, bit1=B, bit2=C |
| senseSel | output | 2 | Floating phase to sample: 0=A, 1=B, 2=C, 3=none |

## Verification
Some properties are checked by the assertions on every cycle:
- no phase ever has both of its switches requested;
- each run state has exactly one low and one high request;
- the selected sense phase is undriven;
- alignment always exits to A;
- the state holds without a step;
- the latched direction never moves outside alignment.

Other behaviour can only be shown by the bench's scenarios:
- the full forward and reverse orders with their exact output codes;
- the one-cycle output latency;
- a direction change during run being ignored and then honoured after reset;
- reset winning over a simultaneous step.

// File: rtl/comm_seq_pkg.sv
package comm_seq_pkg;
  localparam int PHASE_N = 3;
  localparam int SEL_W   = 2;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_ALIGN = 3'd0,
    ST_A     = 3'd1,
    ST_B     = 3'd2,
    ST_C     = 3'd3,
    ST_D     = 3'd4,
    ST_E     = 3'd5,
    ST_F     = 3'd6,
    ST_SPARE = 3'd7
  } commState_t;

  typedef struct packed {
    logic       alignNow;
    commState_t nextState;
  } seqCmd_t;

  localparam logic [SEL_W-1:0] SEL_NONE = 2'd3;
endpackage

// File: rtl/comm_seq_ctrl.sv
module comm_seq_ctrl
  import comm_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stepEn,
  input  logic    dirFwd,
  output seqCmd_t cmd
);
  commState_t stateQ, stateD;
  logic dirQ;

  function automatic commState_t stepFwd(commState_t s);
    return (s == ST_F) ? ST_A : commState_t'(s + 3'd1);
  endfunction

  function automatic commState_t stepRev(commState_t s);
    return (s == ST_A) ? ST_F : commState_t'(s - 3'd1);
  endfunction

  always_comb begin
    stateD = stateQ;
    if (rst) begin
      stateD = ST_ALIGN;
    end else begin
      case (stateQ)
        ST_ALIGN: if (stepEn) stateD = ST_A;
        ST_A, ST_B, ST_C, ST_D, ST_E, ST_F:
          if (stepEn) stateD = dirQ ? stepFwd(stateQ) : stepRev(stateQ);
        default: stateD = ST_ALIGN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    stateQ <= stateD;
    if (rst || stateQ == ST_ALIGN) dirQ <= dirFwd;
  end

  assign cmd.alignNow  = (stateD == ST_ALIGN);
  assign cmd.nextState = stateD;

  assert_align_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ALIGN && stepEn) |=> (stateQ == ST_A));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!stepEn && stateQ != ST_SPARE) |=> $stable(stateQ));

  assert_dir_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (stateQ != ST_ALIGN) |=> $stable(dirQ));

  assert_run_step_R9: assert property (@(posedge clk) disable iff (rst)
    (stepEn && stateQ != ST_ALIGN && stateQ != ST_SPARE) |=> !$stable(stateQ));
endmodule

// File: rtl/comm_seq_datapath.sv
module comm_seq_datapath
  import comm_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  seqCmd_t            cmd,
  output logic [PHASE_N-1:0] lowReq,
  output logic [PHASE_N-1:0] highReq,
  output logic [SEL_W-1:0]   senseSel
);
  localparam logic [PHASE_N-1:0] PH_A = 3'b001;
  localparam logic [PHASE_N-1:0] PH_B = 3'b010;
  localparam logic [PHASE_N-1:0] PH_C = 3'b100;

  logic [PHASE_N-1:0] lowD, highD;
  logic [SEL_W-1:0]   selD;

  always_comb begin
    lowD = PH_B; highD = PH_A | PH_C; selD = SEL_NONE;
    if (!cmd.alignNow) begin
      case (cmd.nextState)
        ST_A: begin lowD = PH_C; highD = PH_A; selD = 2'd1; end
        ST_B: begin lowD = PH_C; highD = PH_B; selD = 2'd0; end
        ST_C: begin lowD = PH_A; highD = PH_B; selD = 2'd2; end
        ST_D: begin lowD = PH_A; highD = PH_C; selD = 2'd1; end
        ST_E: begin lowD = PH_B; highD = PH_C; selD = 2'd0; end
        ST_F: begin lowD = PH_B; highD = PH_A; selD = 2'd2; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    lowReq   <= lowD;
    highReq  <= highD;
    senseSel <= selD;
  end

  assert_no_shoot_R7: assert property (@(posedge clk) disable iff (rst)
    (lowReq & highReq) == '0);

  assert_one_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (senseSel != SEL_NONE) |-> ($countones(lowReq) == 1 && $countones(highReq) == 1));

  assert_float_sense_R8: assert property (@(posedge clk) disable iff (rst)
    (senseSel != SEL_NONE) |-> (((lowReq | highReq) & (3'b001 << senseSel)) == '0));
endmodule

// File: rtl/comm_seq_top.sv
module comm_seq_top
  import comm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stepEn,
  input  logic       dirFwd,
  output logic [2:0] lowReq,
  output logic [2:0] highReq,
  output logic [1:0] senseSel
);
  seqCmd_t cmd;

  comm_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .stepEn(stepEn), .dirFwd(dirFwd), .cmd(cmd)
  );

  comm_seq_datapath u_dp (
    .clk(clk), .rst(rst), .cmd(cmd),
    .lowReq(lowReq), .highReq(highReq), .senseSel(senseSel)
  );
endmodule

// File: tb/comm_seq_tb.sv
module comm_seq_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stepEn = 1'b0;
  logic dirFwd = 1'b1;
  logic [2:0] lowReq, highReq;
  logic [1:0] senseSel;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  comm_seq_top dut_i (
    .clk(clk), .rst(rst), .stepEn(stepEn), .dirFwd(dirFwd),
    .lowReq(lowReq), .highReq(highReq), .senseSel(senseSel)
  );

  localparam logic [7:0] O_R = {3'b010, 3'b101, 2'd3};
  localparam logic [7:0] O_A = {3'b100, 3'b001, 2'd1};
  localparam logic [7:0] O_B = {3'b100, 3'b010, 2'd0};
  localparam logic [7:0] O_C = {3'b001, 3'b010, 2'd2};
  localparam logic [7:0] O_D = {3'b001, 3'b100, 2'd1};
  localparam logic [7:0] O_E = {3'b010, 3'b100, 2'd0};
  localparam logic [7:0] O_F = {3'b010, 3'b001, 2'd2};

  // {resetFirst, dir, expected outputs after one step}
  localparam logic [9:0] VEC [14] = '{
    {1'b1, 1'b1, O_A}, {1'b0, 1'b1, O_B}, {1'b0, 1'b1, O_C}, {1'b0, 1'b1, O_D},
    {1'b0, 1'b1, O_E}, {1'b0, 1'b1, O_F}, {1'b0, 1'b1, O_A},
    {1'b1, 1'b0, O_A}, {1'b0, 1'b0, O_F}, {1'b0, 1'b0, O_E}, {1'b0, 1'b0, O_D},
    {1'b0, 1'b0, O_C}, {1'b0, 1'b0, O_B}, {1'b0, 1'b0, O_A}
  };

  task automatic check(input string req, input logic [7:0] expV);
    checks++;
    if ({lowReq, highReq, senseSel} !== expV) begin
      fails++;
      $display("FAIL %s: got low=%b high=%b sel=%0d, expected low=%b high=%b sel=%0d",
               req, lowReq, highReq, senseSel, expV[7:5], expV[4:2], expV[1:0]);
    end
  endtask

  task automatic doReset(input logic dir);
    @(negedge clk); rst = 1'b1; dirFwd = dir; stepEn = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); stepEn = 1'b1;
    @(negedge clk); stepEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", O_R);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i][9]) begin
        doReset(VEC[i][8]);
        check("R1 align after reset", O_R);
      end
      pulse();
      if (VEC[i][9]) check("R2 align exit", VEC[i][7:0]);
      else if (VEC[i][8]) check("R3 forward order", VEC[i][7:0]);
      else check("R4 reverse order", VEC[i][7:0]);
    end

    // R5: hold without step, in align and in run
    doReset(1'b1);
    idle(3);
    check("R5 hold in align", O_R);
    pulse();
    idle(3);
    check("R5 hold in run", O_A);

    // R6: direction change during run is ignored
    pulse();
    dirFwd = 1'b0;
    pulse();
    check("R6 dir ignored in run", O_C);
    pulse();
    check("R6 dir ignored in run", O_D);
    doReset(1'b0);
    pulse(); pulse();
    check("R6 dir taken after reset", O_F);

    // R9: held enable advances each cycle, one-cycle latency
    doReset(1'b1);
    @(negedge clk); stepEn = 1'b1;
    @(negedge clk);
    check("R9 first held step", O_A);
    @(negedge clk); stepEn = 1'b0;
    check("R9 second held step", O_B);

    // R10: reset beats step
    @(negedge clk); rst = 1'b1; stepEn = 1'b1;
    @(negedge clk); rst = 1'b0; stepEn = 1'b0;
    check("R10 reset priority", O_R);

    // R1: reset from mid-run
    pulse(); pulse(); pulse();
    check("R3 mid-run state", O_C);
    doReset(1'b1);
    check("R1 reset mid-run", O_R);

    finishRun();
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end
endmodule